// File: doc/BRIEF.md
# Serial Port Register and FIFO Front End

This block sits between a 32-bit memory-mapped bus and the byte-level halves of a simple serial port. Software pushes bytes to send into a transmit queue and pulls received bytes out of a receive queue. It watches progress through a status word and sets queue flushes and the interrupt enable through a control word. The bus interface has single-cycle read and write strobes. Read data is registered and is valid on `bus_rdata` in the cycle after the read strobe.

On the line side, an external serializer takes the transmit queue head through a valid/ready handshake. An external deserializer delivers bytes with a single-cycle valid. It cannot be stalled. Each delivered byte carries parity and framing error strobes.

The sticky error flags clear themselves when the status word is read. One interrupt line serves both directions. It combines a level condition while received data is waiting with a one-cycle event when the transmit queue drains.

Top module: `uart_fifo_front`

## Requirements
- R1: After reset both queues are empty, all error flags are clear, interrupts are disabled, the status word reads 0x04, `irq` is low and `tx_valid` is low.
- R2: Register select uses byte address bits 3:2: 0x00 is receive data, 0x04 is transmit data, 0x08 is status and 0x0C is control. Read data appears on `bus_rdata` one cycle after the read strobe. Reads of 0x04 and 0x0C return zero.
- R3: A read of 0x00 with data waiting removes the oldest received byte. It returns that byte in bits 7:0 with bits 31:8 zero, in arrival order.
- R4: A read of 0x00 while the receive queue is empty returns zero and leaves the queue unchanged.
- R5: A write to 0x04 appends `bus_wdata[7:0]` to the 16-entry transmit queue. The head is offered on `tx_byte` with `tx_valid` high and is removed on a cycle with `tx_valid` and `tx_ready` both high. Bytes leave in write order.
- R6: A write to 0x04 while the transmit queue holds 16 bytes is discarded.
- R7: The status word bits are: bit 0 receive data waiting, bit 1 receive queue full (16 bytes), bit 2 transmit queue empty, bit 3 transmit queue full, bit 4 interrupt enable. Bits 31:8 are zero.
- R8: A byte that arrives while the receive queue is full and not being read in that cycle is dropped, and status bit 5 (overrun) is set.
- R9: `rx_par_err` or `rx_frm_err` high with `rx_valid` sets status bit 7 (parity) or bit 6 (framing) respectively.
- R10: A status read returns the error flags and then clears bits 5..7. An error event in the same cycle as that read stays set for the next read.
- R11: A control write with bit 0 set empties the transmit queue, and one with bit 1 set empties the receive queue. Bit 4 of every control write becomes the interrupt enable.
- R12: With interrupts enabled, `irq` is high in every cycle in which the receive queue holds data.
- R13: With interrupts enabled, `irq` pulses for exactly one cycle after the transmit queue goes from non-empty to empty, whether by draining or by a flush. Enabling interrupts while the transmit queue is already empty causes no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| tx_byte | output | 8 | Transmit queue head to the serializer |
| tx_valid | output | 1 | Transmit queue is non-empty |
| tx_ready | input | 1 | Serializer takes the head this cycle |
| rx_byte | input | 8 | Byte from the deserializer |
| rx_valid | input | 1 | `rx_byte` is valid this cycle |
| rx_par_err | input | 1 | Parity error for the byte in this cycle |
| rx_frm_err | input | 1 | Framing error for the byte in this cycle |
| irq | output | 1 | Shared interrupt request |

## Verification
A wrong queue count or pointer shows at the ports within one bus read. The status bits disagree with the modelled occupancy, or a receive read returns a stale or misordered byte. A lost or stuck error flag appears in the very next status read, because each read both reports and clears the flags. A wrong pulse tracker shows as a missing, doubled or spurious `irq` cycle during a transmit drain or a flush. The bench counts `irq` high cycles, so any of these is caught within a few cycles of the event.

// File: rtl/uafe_pkg.sv
package uafe_pkg;

    localparam int BUS_W  = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_RXD  = 2'd0,
        SEL_TXD  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    localparam int CTRL_FLUSH_TX = 0;
    localparam int CTRL_FLUSH_RX = 1;
    localparam int CTRL_IE       = 4;

    typedef struct packed {
        logic par;
        logic frm;
        logic ovr;
    } err_flags_t;

    // Field order is the status bit order, msb first (bit 7 .. bit 0).
    typedef struct packed {
        err_flags_t errs;
        logic       ie;
        logic       tx_full;
        logic       tx_empty;
        logic       rx_full;
        logic       rx_avail;
    } stat_word_t;

    function automatic logic [BUS_W-1:0] pack_status(input stat_word_t s);
        return {{(BUS_W-$bits(stat_word_t)){1'b0}}, s};
    endfunction

    function automatic logic [BUS_W-1:0] pack_byte(input logic [BYTE_W-1:0] b);
        return {{(BUS_W-BYTE_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/uafe_byte_fifo.sv
module uafe_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             dropped
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty && !flush;
    assign do_push = push && !flush && (!full || do_pop);
    assign dropped = push && !flush && full && !do_pop;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // R6: occupancy never exceeds the depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R4: a pop on an empty queue with nothing else happening leaves it empty
    a_r4_idle_pop_holds: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/uafe_err_tracker.sv
module uafe_err_tracker
    import uafe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  err_flags_t ev,
    output err_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (clr ? err_flags_t'('0) : flags) | ev;
        end
    end

    // R10: an event that coincides with a clearing read is kept
    a_r10_event_survives_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && ev.par) |=> flags.par);

    // R8: an overrun event is visible the next cycle
    a_r8_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        ev.ovr |=> flags.ovr);

endmodule

// File: rtl/uafe_irq_unit.sv
module uafe_irq_unit (
    input  logic clk,
    input  logic rst,
    input  logic ie,
    input  logic rx_nonempty,
    input  logic tx_empty,
    output logic irq
);
    logic tx_empty_q;
    logic drain_pulse;

    always_ff @(posedge clk) begin
        if (rst) tx_empty_q <= 1'b1;
        else     tx_empty_q <= tx_empty;
    end

    assign drain_pulse = ie && tx_empty && !tx_empty_q;
    assign irq         = (ie && rx_nonempty) || drain_pulse;

    // R13: with no receive data pending, a drain pulse never lasts two cycles
    a_r13_pulse_single: assert property (@(posedge clk) disable iff (rst)
        (irq && !rx_nonempty) |=> !(irq && !rx_nonempty));

endmodule

// File: rtl/uart_fifo_front.sv
module uart_fifo_front
    import uafe_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    output logic              irq
);
    reg_sel_e   sel;
    logic       wr_txd, wr_ctrl, rd_rxd, rd_stat;
    logic       tx_empty, tx_full, tx_drop;
    logic       rx_empty, rx_full, rx_drop;
    logic [7:0] rx_head;
    logic       ie_q;
    err_flags_t err_ev, err_q;
    stat_word_t stat;
    logic [BUS_W-1:0] rdata_q, rdata_d;

    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign wr_txd  = bus_wr && (sel == SEL_TXD);
    assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
    assign rd_rxd  = bus_rd && (sel == SEL_RXD);
    assign rd_stat = bus_rd && (sel == SEL_STAT);

    uafe_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_tx_q (
        .clk     (clk),
        .rst     (rst),
        .flush   (wr_ctrl && bus_wdata[CTRL_FLUSH_TX]),
        .push    (wr_txd),
        .din     (bus_wdata[BYTE_W-1:0]),
        .pop     (tx_ready),
        .dout    (tx_byte),
        .empty   (tx_empty),
        .full    (tx_full),
        .dropped (tx_drop)
    );

    uafe_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_rx_q (
        .clk     (clk),
        .rst     (rst),
        .flush   (wr_ctrl && bus_wdata[CTRL_FLUSH_RX]),
        .push    (rx_valid),
        .din     (rx_byte),
        .pop     (rd_rxd),
        .dout    (rx_head),
        .empty   (rx_empty),
        .full    (rx_full),
        .dropped (rx_drop)
    );

    assign tx_valid = !tx_empty;

    always_ff @(posedge clk) begin
        if (rst)          ie_q <= 1'b0;
        else if (wr_ctrl) ie_q <= bus_wdata[CTRL_IE];
    end

    always_comb begin
        err_ev.ovr = rx_drop;
        err_ev.par = rx_valid && rx_par_err;
        err_ev.frm = rx_valid && rx_frm_err;
    end

    uafe_err_tracker u_errs (
        .clk   (clk),
        .rst   (rst),
        .clr   (rd_stat),
        .ev    (err_ev),
        .flags (err_q)
    );

    uafe_irq_unit u_irq (
        .clk         (clk),
        .rst         (rst),
        .ie          (ie_q),
        .rx_nonempty (!rx_empty),
        .tx_empty    (tx_empty),
        .irq         (irq)
    );

    always_comb begin
        stat.errs     = err_q;
        stat.ie       = ie_q;
        stat.tx_full  = tx_full;
        stat.tx_empty = tx_empty;
        stat.rx_full  = rx_full;
        stat.rx_avail = !rx_empty;
    end

    always_comb begin
        unique case (sel)
            SEL_RXD:  rdata_d = rx_empty ? '0 : pack_byte(rx_head);
            SEL_STAT: rdata_d = pack_status(stat);
            default:  rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;

    // R4: reading an empty receive queue yields zero
    a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_rxd && rx_empty) |=> (bus_rdata == '0));

    // R3: received data reads never set bits above the byte
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_rxd |=> (bus_rdata[31:8] == '0));

endmodule

// File: tb/uart_fifo_front_tb_top.sv
module uart_fifo_front_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        rx_par_err = 1'b0;
    logic        rx_frm_err = 1'b0;
    logic        irq;

    always #2 clk = ~clk;

    uart_fifo_front dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .irq(irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model
    logic [7:0] m_rx[$];
    logic [7:0] m_tx[$];
    bit m_ie, m_ovr, m_frm, m_par;

    function automatic logic [31:0] exp_status();
        return {24'b0, m_par, m_frm, m_ovr, m_ie,
                m_tx.size() == 16, m_tx.size() == 0,
                m_rx.size() == 16, m_rx.size() != 0};
    endfunction

    function automatic logic exp_irq_level();
        return m_ie && (m_rx.size() != 0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b, input bit p, input bit f);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_par_err = p; rx_frm_err = f;
        @(negedge clk);
        rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
        if (p) m_par = 1;
        if (f) m_frm = 1;
        if (m_rx.size() == 16) m_ovr = 1;
        else m_rx.push_back(b);
    endtask

    task automatic do_status(input string req);
        logic [31:0] d;
        bus_read(4'h8, d);
        check(req, d, exp_status());
        m_ovr = 0; m_frm = 0; m_par = 0;
    endtask

    task automatic do_rx_read(input string req);
        logic [31:0] d;
        logic [31:0] e;
        bus_read(4'h0, d);
        e = (m_rx.size() == 0) ? 32'h0 : {24'h0, m_rx.pop_front()};
        check(req, d, e);
    endtask

    task automatic do_tx_write(input logic [7:0] b);
        bus_write(4'h4, {24'hABCDEF, b});
        if (m_tx.size() < 16) m_tx.push_back(b);
    endtask

    task automatic do_ctrl(input logic [31:0] v);
        bus_write(4'hC, v);
        if (v[0]) m_tx.delete();
        if (v[1]) m_rx.delete();
        m_ie = v[4];
    endtask

    // drain the transmit queue with receive queue empty; count irq cycles
    task automatic drain_tx(input string req);
        int pulses = 0;
        bit had = (m_tx.size() != 0);
        @(negedge clk);
        tx_ready = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (tx_valid) begin
                if (m_tx.size() == 0) check({req, " extra byte"}, {24'h0, tx_byte}, 32'hFFFF_FFFF);
                else check({req, " byte order"}, {24'h0, tx_byte}, {24'h0, m_tx.pop_front()});
            end
            if (irq) pulses++;
            @(negedge clk);
        end
        tx_ready = 1'b0;
        check({req, " tx_valid after drain"}, {31'h0, tx_valid}, 32'h0);
        check("R13 drain pulse count", pulses, (had && m_ie) ? 1 : 0);
    endtask

    initial begin
        logic [31:0] d;
        m_ie = 0; m_ovr = 0; m_frm = 0; m_par = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
        do_status("R1 status after reset");
        check("R1 status constant", exp_status(), 32'h4);

        // R2 unreadable offsets, ignored writes
        bus_read(4'h4, d); check("R2 read tx offset", d, 32'h0);
        bus_read(4'hC, d); check("R2 read ctrl offset", d, 32'h0);
        bus_write(4'h8, 32'hFF);
        bus_write(4'h0, 32'h55);
        do_status("R2 writes to read-only offsets ignored");

        // R3, R4 receive order and empty read
        do_rx_read("R4 empty read zero");
        rx_send(8'h11, 0, 0); rx_send(8'h22, 0, 0); rx_send(8'hF3, 0, 0);
        do_rx_read("R3 first"); do_rx_read("R3 second"); do_rx_read("R3 third");
        do_rx_read("R4 empty after drain");
        do_status("R4 status unchanged by empty read");

        // R12 level interrupt
        do_ctrl(32'h10);
        check("R12 no irq when empty", {31'h0, irq}, 32'h0);
        rx_send(8'h5A, 0, 0);
        check("R12 irq level", {31'h0, irq}, {31'h0, exp_irq_level()});
        repeat (3) @(negedge clk);
        check("R12 irq held", {31'h0, irq}, 32'h1);
        do_rx_read("R3 read clears level");
        check("R12 irq drops", {31'h0, irq}, 32'h0);

        // R13 no pulse when enabling with empty transmit queue
        do_ctrl(32'h00);
        do_ctrl(32'h10);
        begin
            int hi = 0;
            for (int i = 0; i < 5; i++) begin
                if (irq) hi++;
                @(negedge clk);
            end
            check("R13 no pulse on enable", hi, 0);
        end

        // R5 transmit order, R13 drain pulse
        do_tx_write(8'hA1); do_tx_write(8'hB2); do_tx_write(8'hC3);
        check("R5 tx_valid", {31'h0, tx_valid}, 32'h1);
        drain_tx("R5");

        // R6 full transmit queue
        for (int i = 0; i < 17; i++) do_tx_write(8'(i + 8'h40));
        do_status("R6 tx full status");
        check("R6 model count", m_tx.size(), 16);

        // R11 flush both, R13 pulse from flush
        rx_send(8'h01, 0, 0); rx_send(8'h02, 0, 0);
        do_ctrl(32'h13);
        check("R13 flush pulse", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R13 flush pulse ends", {31'h0, irq}, 32'h0);
        do_status("R11 after flush");
        do_rx_read("R11 rx empty after flush");

        // R8 overrun, R7 full bits
        for (int i = 0; i < 17; i++) rx_send(8'(8'h80 + i), 0, 0);
        do_status("R8 overrun and R7 rx full");
        do_status("R10 flags cleared by read");
        for (int i = 0; i < 16; i++) do_rx_read("R8 kept bytes");

        // R9 error strobes
        rx_send(8'h77, 1, 0);
        rx_send(8'h78, 0, 1);
        do_status("R9 parity and framing");
        do_status("R10 cleared");

        // R10 event coinciding with a status read
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'h8;
        rx_valid = 1'b1; rx_byte = 8'h99; rx_par_err = 1'b1;
        d = exp_status();
        @(negedge clk);
        bus_rd = 1'b0; rx_valid = 1'b0; rx_par_err = 1'b0;
        check("R10 snapshot before event", bus_rdata, d);
        m_ovr = 0; m_frm = 0; m_par = 1;
        if (m_rx.size() < 16) m_rx.push_back(8'h99);
        do_status("R10 event survives read");
        do_ctrl(32'h02);

        // random mix (transmit side held, so no drain pulses)
        void'($urandom(32'd1234));
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 9);
            if (op < 3) rx_send(8'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
            else if (op < 5) do_rx_read("R3 random read");
            else if (op < 7) do_tx_write(8'($urandom));
            else if (op < 9) do_status("R7 random status");
            else do_ctrl({27'h0, 1'($urandom), 4'h0});
            check("R12 random irq", {31'h0, irq}, {31'h0, exp_irq_level()});
        end

        do_ctrl(32'h12);
        drain_tx("R5 random");
        do_status("R7 final status");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule